// File: doc/BRIEF.md
# Randomised Capacitor Role Controller for a 2.5-bit MDAC Stage

This block drives the switches of a four-capacitor multiplying DAC in the front stage of a pipelined converter. All four capacitors sample the input together. At the end of each conversion decision, the block reads the six comparator outputs of the stage's sub-converter as a thermometer code. It picks one capacitor to close the amplifier feedback loop and gives each of the other three a reference command: positive reference, zero, or negative reference. The three weights always add up to the level the comparators chose. The only thing that changes from one conversion to the next is which physical cell plays which role.

The role assignment is rotated pseudo-randomly on every conversion. A 16-bit maximal-length shift register provides the randomness. Gain and mismatch errors between cells are therefore spread into noise instead of building up as harmonic distortion. A control input turns the rotation off. The block then uses a fixed feedback cell and a fixed weight order, which suits characterisation. Comparator patterns that are not a clean thermometer code are still resolved by counting their ones, and a flag reports them.

The results are registered on a conversion strobe. They stay constant through the amplify phase that follows. The stage's digital output code does not depend on this block.

Top module: `dem_cap_ctrl`

## Requirements
- R1: While `rst_n` is low, `fb_sel` is 4'b0001, `ref_cmd` is all zero, `bubble_err` is 0, and the random register is loaded with the seed 16'hACE1.
- R2: With `dem_en` high, the capacitor index placed in feedback is bits [1:0] of the random register at the strobe, and `fb_sel` has exactly that one bit set.
- R3: The random register is a 16-bit shift register. Each strobe shifts it left by one and feeds bit15^bit13^bit12^bit10 into bit 0. It moves only on a strobe, whether `dem_en` is high or low.
- R4: Let k be the number of ones in `comp_therm`, and t = k-3. The three weights come from a base list of three slots. For t>0 the first t slots are +1, for t<0 the first -t slots are -1, and every other slot is 0. The weights on the three non-feedback capacitors therefore always add up to t.
- R5: `ref_cmd` holds 2 bits per capacitor, with capacitor i at bits [2i+1:2i]. The codes are 00 for zero, 01 for +Vref and 11 for -Vref. The feedback capacitor always gets 00. The other capacitors, in ascending index order, take slots P[p][0], P[p][1] and P[p][2] of the base list. Here p = (random bits [4:2]) mod 6, and P is: 0:(0,1,2), 1:(0,2,1), 2:(1,0,2), 3:(1,2,0), 4:(2,0,1), 5:(2,1,0).
- R6: `bubble_err` is 1 after a strobe whose `comp_therm` is not of the form 2^k-1 (ones filling from bit 0 upward), and 0 otherwise. The weights still follow the count of ones.
- R7: With `dem_en` low, the feedback capacitor is index 0 and the permutation is p=0.
- R8: The outputs change only on the clock edge where `conv_strobe` is high, and they are visible from the next cycle. Between strobes they hold their values, whatever the other inputs do.
- R9: The code 10 never appears in any field of `ref_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_strobe | input | 1 | One pulse per conversion; captures the decision and advances the random register |
| comp_therm | input | 6 | Comparator outputs, bit 0 is the lowest threshold |
| dem_en | input | 1 | 1 selects randomised roles, 0 selects the fixed assignment |
| fb_sel | output | 4 | One-hot feedback capacitor select |
| ref_cmd | output | 8 | Per-capacitor reference command, 2 bits per cell |
| bubble_err | output | 1 | Last captured comparator pattern was not a thermometer code |

## Verification
A wrong random register state shows up at the first strobe afterwards. A bad feedback index or permutation appears in `fb_sel` or in the order of `ref_cmd`, and the per-cycle comparison flags it in the next cycle. A corrupted shift rule may leave the first outputs correct, but it diverges within a few conversions because the bench steps its own copy of the sequence. Errors in the weight split or the count show up at once as a wrong sum or a wrong field, for the affected comparator level. A register that updates without a strobe is caught in the first idle cycle after it happens.

// File: rtl/dem_pkg.sv
// Shared constants and helpers for the capacitor role controller.
// Assumes a four-cell MDAC: one feedback cell and three weighted cells.
package dem_pkg;
    localparam int N_COMP = 6;             // comparators in the sub-converter
    localparam int N_WT   = N_COMP / 2;    // weighted cells
    localparam int N_CAP  = N_WT + 1;      // total cells
    localparam int CMD_W  = 2;             // bits per cell command
    localparam int CNT_W  = $clog2(N_COMP + 1);
    localparam int IDX_W  = $clog2(N_CAP);
    localparam int PRM_W  = 3;             // raw bits used for the permutation

    localparam logic [CMD_W-1:0] CMD_ZERO = 2'b00;
    localparam logic [CMD_W-1:0] CMD_POS  = 2'b01;
    localparam logic [CMD_W-1:0] CMD_NEG  = 2'b11;

    // Base-list slot used by the given output position under permutation p.
    function automatic logic [1:0] perm_slot(input logic [2:0] p, input int pos);
        logic [5:0] row;
        case (p)
            3'd0:    row = {2'd2, 2'd1, 2'd0};
            3'd1:    row = {2'd1, 2'd2, 2'd0};
            3'd2:    row = {2'd2, 2'd0, 2'd1};
            3'd3:    row = {2'd0, 2'd2, 2'd1};
            3'd4:    row = {2'd1, 2'd0, 2'd2};
            default: row = {2'd0, 2'd1, 2'd2};
        endcase
        return row[pos*2 +: 2];
    endfunction
endpackage

// File: rtl/dem_lfsr.sv
// Fibonacci shift register used as the role randomiser.
// Assumes a nonzero seed; it shifts left once per enable pulse.
module dem_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SEED = 16'hACE1,
    parameter logic [W-1:0]    TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic feed;

    // Feedback bit: parity of the tapped positions.
    always_comb feed = ^(state & TAPS);

    // Register update: load seed on reset, shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {state[W-2:0], feed};
    end
endmodule

// File: rtl/dem_therm_decode.sv
// Counts the ones of the comparator word and flags non-thermometer words.
// Assumes bit 0 is the lowest threshold comparator.
module dem_therm_decode
    import dem_pkg::*;
(
    input  logic [N_COMP-1:0] therm,
    output logic [CNT_W-1:0]  count,
    output logic              bubble
);
    // Population count followed by a shape check against the ideal fill.
    always_comb begin
        count  = '0;
        bubble = 1'b0;
        for (int i = 0; i < N_COMP; i++)
            count = count + CNT_W'(therm[i]);
        for (int i = 0; i < N_COMP; i++)
            if (therm[i] != (CNT_W'(i) < count)) bubble = 1'b1;
    end
endmodule

// File: rtl/dem_weight_map.sv
// Splits the total level into three unit weights and places them on the
// non-feedback cells following a chosen permutation.
// Assumes count <= N_COMP and perm_idx < 6.
module dem_weight_map
    import dem_pkg::*;
(
    input  logic [CNT_W-1:0]       count,
    input  logic [IDX_W-1:0]       fb_idx,
    input  logic [PRM_W-1:0]       perm_idx,
    output logic [N_CAP-1:0]       fb_onehot,
    output logic [N_CAP*CMD_W-1:0] cmd
);
    logic signed [CNT_W:0]   total;
    logic [CMD_W-1:0]        base [N_WT];

    // Level relative to mid-scale.
    always_comb total = $signed({1'b0, count}) - (CNT_W+1)'(N_WT);

    // Fixed split of the level into the base slot list.
    always_comb begin
        for (int s = 0; s < N_WT; s++) begin
            if (total > s)        base[s] = CMD_POS;
            else if (-total > s)  base[s] = CMD_NEG;
            else                  base[s] = CMD_ZERO;
        end
    end

    // Cell assignment: feedback cell gets zero, the rest take permuted slots.
    always_comb begin
        int pos;
        pos       = 0;
        fb_onehot = '0;
        cmd       = '0;
        for (int c = 0; c < N_CAP; c++) begin
            if (IDX_W'(c) == fb_idx) begin
                fb_onehot[c] = 1'b1;
            end else begin
                cmd[c*CMD_W +: CMD_W] = base[perm_slot(perm_idx, pos)];
                pos = pos + 1;
            end
        end
    end
endmodule

// File: rtl/dem_cap_ctrl.sv
// Top of the capacitor role controller. On each conversion strobe it
// samples the comparator word, derives the feedback cell and reference
// commands (randomised or fixed), and holds them for the amplify phase.
// Assumes conv_strobe pulses once per conversion.
module dem_cap_ctrl
    import dem_pkg::*;
#(
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_strobe,
    input  logic [N_COMP-1:0]      comp_therm,
    input  logic                   dem_en,
    output logic [N_CAP-1:0]       fb_sel,
    output logic [N_CAP*CMD_W-1:0] ref_cmd,
    output logic                   bubble_err
);
    localparam logic [N_CAP-1:0] FB_RESET = N_CAP'(1);

    logic [LFSR_W-1:0]       rnd;
    logic [CNT_W-1:0]        count;
    logic                    bubble;
    logic [IDX_W-1:0]        fb_idx;
    logic [PRM_W-1:0]        perm_raw;
    logic [PRM_W-1:0]        perm_idx;
    logic [N_CAP-1:0]        fb_next;
    logic [N_CAP*CMD_W-1:0]  cmd_next;

    dem_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (conv_strobe),
        .state (rnd)
    );

    dem_therm_decode u_dec (
        .therm  (comp_therm),
        .count  (count),
        .bubble (bubble)
    );

    // Role selection: random bits when enabled, fixed choice otherwise.
    always_comb begin
        perm_raw = rnd[IDX_W +: PRM_W];
        if (dem_en) begin
            fb_idx   = rnd[IDX_W-1:0];
            perm_idx = (perm_raw >= PRM_W'(6)) ? perm_raw - PRM_W'(6) : perm_raw;
        end else begin
            fb_idx   = '0;
            perm_idx = '0;
        end
    end

    dem_weight_map u_map (
        .count     (count),
        .fb_idx    (fb_idx),
        .perm_idx  (perm_idx),
        .fb_onehot (fb_next),
        .cmd       (cmd_next)
    );

    // Output registers: capture on strobe, hold through amplify phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_sel     <= FB_RESET;
            ref_cmd    <= '0;
            bubble_err <= 1'b0;
        end else if (conv_strobe) begin
            fb_sel     <= fb_next;
            ref_cmd    <= cmd_next;
            bubble_err <= bubble;
        end
    end
endmodule

// File: rtl/dem_cap_ctrl_chk.sv
// Property checker for dem_cap_ctrl, attached by bind.
module dem_cap_ctrl_chk
    import dem_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   conv_strobe,
    input logic [N_COMP-1:0]      comp_therm,
    input logic                   dem_en,
    input logic [N_CAP-1:0]       fb_sel,
    input logic [N_CAP*CMD_W-1:0] ref_cmd,
    input logic                   bubble_err
);
    function automatic int wsum(input logic [N_CAP*CMD_W-1:0] c);
        int s;
        s = 0;
        for (int i = 0; i < N_CAP; i++) begin
            if (c[i*CMD_W +: CMD_W] == CMD_POS) s = s + 1;
            if (c[i*CMD_W +: CMD_W] == CMD_NEG) s = s - 1;
        end
        return s;
    endfunction

    function automatic logic fb_cell_zero(input logic [N_CAP-1:0] f,
                                          input logic [N_CAP*CMD_W-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N_CAP; i++)
            if (f[i] && c[i*CMD_W +: CMD_W] != CMD_ZERO) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic has_bad_code(input logic [N_CAP*CMD_W-1:0] c);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < N_CAP; i++)
            if (c[i*CMD_W +: CMD_W] == 2'b10) bad = 1'b1;
        return bad;
    endfunction

    a_r2_fb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fb_sel) == 1);

    a_r5_fb_cell_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fb_cell_zero(fb_sel, ref_cmd));

    a_r4_weight_sum: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> wsum(ref_cmd) == $countones($past(comp_therm)) - N_WT);

    a_r7_fixed_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_strobe && !dem_en) |=> fb_sel == N_CAP'(1));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_strobe |=> ($stable(fb_sel) && $stable(ref_cmd) && $stable(bubble_err)));

    a_r6_clean_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_strobe && ((comp_therm & (comp_therm + 1'b1)) == '0)) |=> !bubble_err);

    a_r9_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        !has_bad_code(ref_cmd));
endmodule

bind dem_cap_ctrl dem_cap_ctrl_chk u_chk (.*);

// File: tb/dem_cap_ctrl_bench.sv
module dem_cap_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_strobe = 1'b0;
    logic [5:0] comp_therm = '0;
    logic       dem_en = 1'b1;
    logic [3:0] fb_sel;
    logic [7:0] ref_cmd;
    logic       bubble_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    int lf;
    logic [3:0] e_fb;
    logic [7:0] e_cmd;
    logic       e_bub;
    bit seen_fb [4];

    int perm_tab [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

    always #10 clk = ~clk;

    dem_cap_ctrl u_dem_cap_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe),
        .comp_therm(comp_therm), .dem_en(dem_en),
        .fb_sel(fb_sel), .ref_cmd(ref_cmd), .bubble_err(bubble_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of one capture: uses the register value before it advances.
    task automatic model_capture(input logic [5:0] th, input logic en);
        int k, t, fbi, p, pos;
        int base [3];
        k = 0;
        for (int i = 0; i < 6; i++) k += th[i];
        t = k - 3;
        for (int s = 0; s < 3; s++)
            base[s] = (t > s) ? 1 : ((-t > s) ? -1 : 0);
        fbi = en ? (lf & 3) : 0;
        p   = en ? (((lf >> 2) & 7) % 6) : 0;
        e_fb = 4'b0001 << fbi;
        e_cmd = '0;
        pos = 0;
        for (int c = 0; c < 4; c++) begin
            if (c != fbi) begin
                int w;
                w = base[perm_tab[p][pos]];
                e_cmd[c*2 +: 2] = (w == 1) ? 2'b01 : ((w == -1) ? 2'b11 : 2'b00);
                pos++;
            end
        end
        e_bub = (int'(th) != ((1 << k) - 1));
        if (en) seen_fb[fbi] = 1;
        lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
    endtask

    // One clock: drive at negedge, model at the edge, compare after it.
    task automatic step(input logic s, input logic [5:0] th, input logic en, input string tag);
        @(negedge clk);
        conv_strobe = s;
        comp_therm  = th;
        dem_en      = en;
        @(posedge clk);
        if (s) model_capture(th, en);
        #1;
        check({tag, " fb_sel"},  int'(fb_sel),  int'(e_fb));
        check({tag, " ref_cmd"}, int'(ref_cmd), int'(e_cmd));
        check({tag, " bubble"},  int'(bubble_err), int'(e_bub));
    endtask

    function automatic logic [5:0] therm_of(input int k);
        return 6'((1 << k) - 1);
    endfunction

    initial begin
        fork
            begin : stim
                lf = 16'hACE1;
                e_fb = 4'b0001; e_cmd = '0; e_bub = 0;
                repeat (3) @(posedge clk);
                #1;
                check("R1 reset fb_sel", int'(fb_sel), 1);
                check("R1 reset ref_cmd", int'(ref_cmd), 0);
                check("R1 reset bubble", int'(bubble_err), 0);
                @(negedge clk); rst_n = 1'b1;
                // R2 R3 R4 R5: randomised conversions over every level
                for (int r = 0; r < 12; r++)
                    for (int k = 0; k <= 6; k++)
                        step(1'b1, therm_of(k), 1'b1, "R2/R4/R5 dem on");
                // R8: idle cycles with changing inputs must hold outputs
                for (int i = 0; i < 6; i++)
                    step(1'b0, 6'(i * 11), i[0], "R8 hold");
                // R6: bubble patterns
                step(1'b1, 6'b000101, 1'b1, "R6 bubble");
                step(1'b1, 6'b100000, 1'b1, "R6 bubble");
                step(1'b1, 6'b011110, 1'b1, "R6 bubble");
                step(1'b1, 6'b000111, 1'b1, "R6 clean");
                // R7: fixed assignment; R3 register still advances
                for (int k = 0; k <= 6; k++)
                    step(1'b1, therm_of(k), 1'b0, "R7 dem off");
                step(1'b1, 6'b110101, 1'b0, "R7/R6 dem off bubble");
                // R3: back on, sequence must continue from advanced state
                for (int r = 0; r < 4; r++)
                    for (int k = 0; k <= 6; k++)
                        step(1'b1, therm_of(6 - k), 1'b1, "R3 sequence");
                step(1'b0, 6'b111111, 1'b1, "R8 hold");
                for (int c = 0; c < 4; c++)
                    check($sformatf("R2 feedback index %0d used", c), int'(seen_fb[c]), 1);
                // R1: reset again mid-run
                @(negedge clk); rst_n = 1'b0;
                @(posedge clk); #1;
                lf = 16'hACE1; e_fb = 4'b0001; e_cmd = '0; e_bub = 0;
                check("R1 re-reset fb_sel", int'(fb_sel), 1);
                check("R1 re-reset ref_cmd", int'(ref_cmd), 0);
                @(negedge clk); rst_n = 1'b1;
                step(1'b1, therm_of(5), 1'b1, "R1 seed reload");
                done = 1;
            end
            begin : watchdog
                repeat (20000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog actual=timeout expected=done");
                end
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule